// File: doc/BRIEF.md
# DRAM Refresh Interval Timer

This block paces the auto-refresh (CAS-before-RAS) traffic of an SDRAM controller. A 3-bit rate code picks one of five refresh intervals, each twice as long as the one before it. A 2-bit clock-speed select sets the base interval for a 100 MHz or 66 MHz memory clock. When an interval runs out, the block adds one to a count of owed refreshes. It keeps a refresh request raised toward the command scheduler for as long as that count is not zero. Each grant from the scheduler pays back one owed refresh.

During suspend a type bit chooses what happens. With the bit set, the interval timer stops and the block raises a self-refresh request in place of timed refreshes. With the bit clear, timed refreshes carry on even if the normal-refresh enable is off. Changing the rate code or the clock select starts the interval again from the beginning, and refreshes already owed are kept.

Top module: `refr_timer`

## Requirements
- R1: After reset, and for as long as reset is held, ref_req, self_ref_req and owed_cnt are all 0, and the interval counter is cleared.
- R2: Rate code 000 turns refresh off. The reserved codes 110 and 111 also produce no interval expiry, so owed_cnt never rises while one of these codes is applied.
- R3: Rate codes 001 through 101 give an interval of base × 2^(code−1) clocks. The first expiry comes exactly one interval after the first clock edge with valid settings. Later expiries follow every interval after that.
- R4: freq_sel 00 selects the 100 MHz base (BASE_HI, 1560 clocks by default). freq_sel 10 selects the 66 MHz base (BASE_LO, 1030 clocks by default). The reserved selects 01 and 11 produce no expiry.
- R5: While nref_en is 0 and susp_req is 0, the interval counter is held at zero and owed_cnt does not grow. When nref_en is set again, a full interval is timed from that edge.
- R6: ref_req is 1 exactly when owed_cnt is not 0 and self-refresh is not active. A ref_gnt sampled while ref_req is 1 lowers owed_cnt by one on the next edge. A ref_gnt sampled while ref_req is 0 has no effect.
- R7: Each expiry adds one to owed_cnt, up to a limit of OWE_MAX (8 by default); further expiries at the limit are dropped. If an expiry and an accepted grant fall on the same edge, owed_cnt stays the same.
- R8: A change in rate_code or freq_sel restarts the interval, counting the edge of the change as its first clock. owed_cnt is not changed by the restart.
- R9: With susp_req=1 and susp_self=1, self_ref_req goes to 1 on the next edge and ref_req goes to 0. The interval counter is held at zero, grants are ignored and owed_cnt is kept. Once suspend ends, ref_req comes back on the next edge and a full interval is timed.
- R10: With susp_req=1 and susp_self=0, timed refresh continues even when nref_en is 0, and self_ref_req stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_code | input | 3 | Refresh rate selection (000 off, 001..101 intervals, 110/111 reserved) |
| freq_sel | input | 2 | Clock speed select (00 = 100 MHz, 10 = 66 MHz, others reserved) |
| nref_en | input | 1 | Normal refresh enable |
| susp_req | input | 1 | Suspend is in progress |
| susp_self | input | 1 | Suspend refresh type: 1 = self-refresh, 0 = keep timed refresh |
| ref_gnt | input | 1 | Scheduler grant for one refresh command |
| ref_req | output | 1 | Refresh request, held until owed refreshes are granted |
| self_ref_req | output | 1 | Request to put the devices into self-refresh |
| owed_cnt | output | $clog2(OWE_MAX+1) | Number of refreshes owed to the devices |

## Verification
The hardest state to reach is a full owed counter that then sees an expiry and a grant on the same edge. Getting there takes OWE_MAX+1 back-to-back intervals with no grant, and the grant then has to land on the exact edge of the next expiry. The bench uses small base counts, works out every expiry edge from the interval formula, and raises the grant one cycle ahead of the computed edge. Rate changes in the middle of an interval, and leaving self-refresh with refreshes still owed, are scheduled the same way, so that each restart and each kept count shows up on a known cycle.

// File: rtl/refr_pkg.sv
package refr_pkg;

  localparam int RATE_W   = 3;
  localparam int FREQ_W   = 2;
  localparam int MAX_STEP = 5;              // highest rate code that refreshes
  localparam int DOUBLES  = MAX_STEP - 1;   // doublings above the base interval

  typedef enum logic [FREQ_W-1:0] {
    FREQ_100  = 2'b00,
    FREQ_RSV1 = 2'b01,
    FREQ_66   = 2'b10,
    FREQ_RSV3 = 2'b11
  } freq_e;

  // Rate codes that actually select an interval.
  function automatic logic code_selects_rate(input logic [RATE_W-1:0] code);
    return (code >= 3'd1) && (code <= 3'(MAX_STEP));
  endfunction

  // Clock selects that carry a defined base count.
  function automatic logic freq_supported(input logic [FREQ_W-1:0] fsel);
    return (fsel == FREQ_100) || (fsel == FREQ_66);
  endfunction

  // Interval length in clocks for rate step 1..MAX_STEP.
  function automatic int unsigned interval_clocks(input int unsigned base,
                                                  input int unsigned step);
    return base << (step - 1);
  endfunction

  // Owed counter update: one add per expiry, one take per accepted grant.
  function automatic int unsigned owed_next(input int unsigned cur,
                                            input logic add,
                                            input logic take,
                                            input int unsigned cap);
    if (add && !take) return (cur < cap) ? cur + 1 : cur;
    if (take && !add) return (cur > 0) ? cur - 1 : cur;
    return cur;
  endfunction

endpackage

// File: rtl/refr_rate_decode.sv
module refr_rate_decode
  import refr_pkg::*;
#(
  parameter int BASE_HI = 1560,
  parameter int BASE_LO = 1030,
  parameter int CNT_W   = 16
) (
  input  logic [RATE_W-1:0] rate_code,
  input  logic [FREQ_W-1:0] freq_sel,
  output logic              cfg_ok,
  output logic [CNT_W-1:0]  period
);

  localparam int NCODES = 1 << RATE_W;

  logic [CNT_W-1:0] per_hi [NCODES];
  logic [CNT_W-1:0] per_lo [NCODES];

  // One interval per code and clock select; unused codes hold zero.
  for (genvar s = 0; s < NCODES; s++) begin : g_step
    if (s >= 1 && s <= MAX_STEP) begin : g_live
      assign per_hi[s] = CNT_W'(interval_clocks(BASE_HI, s));
      assign per_lo[s] = CNT_W'(interval_clocks(BASE_LO, s));
    end else begin : g_dead
      assign per_hi[s] = '0;
      assign per_lo[s] = '0;
    end
  end

  always_comb begin
    cfg_ok = code_selects_rate(rate_code) && freq_supported(freq_sel);
    period = '0;
    if (cfg_ok) begin
      period = (freq_sel == FREQ_66) ? per_lo[rate_code] : per_hi[rate_code];
    end
  end

endmodule

// File: rtl/refr_interval_ctr.sv
module refr_interval_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             reload,
  input  logic [CNT_W-1:0] period,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == period - CNT_W'(1));
  assign tick   = run && !reload && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (reload) begin
      cnt_q <= CNT_W'(1);          // the edge of the change counts as clock one
    end else if (at_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/refr_owed_tracker.sv
module refr_owed_tracker
  import refr_pkg::*;
#(
  parameter int OWE_MAX = 8,
  parameter int OW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          add,
  input  logic          take,
  output logic [OW-1:0] owed
);

  logic [OW-1:0] owed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed_q <= '0;
    end else begin
      owed_q <= OW'(owed_next(int'(owed_q), add, take, OWE_MAX));
    end
  end

  assign owed = owed_q;

endmodule

// File: rtl/refr_timer.sv
module refr_timer
  import refr_pkg::*;
#(
  parameter int BASE_HI = 1560,
  parameter int BASE_LO = 1030,
  parameter int OWE_MAX = 8,
  localparam int OW     = $clog2(OWE_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_code,
  input  logic [FREQ_W-1:0] freq_sel,
  input  logic              nref_en,
  input  logic              susp_req,
  input  logic              susp_self,
  input  logic              ref_gnt,
  output logic              ref_req,
  output logic              self_ref_req,
  output logic [OW-1:0]     owed_cnt
);

  localparam int MAXB  = (BASE_HI > BASE_LO) ? BASE_HI : BASE_LO;
  localparam int CNT_W = $clog2(MAXB * (1 << DOUBLES) + 1);

  logic                     cfg_ok;
  logic [CNT_W-1:0]         period;
  logic [RATE_W+FREQ_W-1:0] cfg_q;
  logic                     reload;
  logic                     self_now;
  logic                     self_q;
  logic                     run;
  logic                     tick;
  logic                     grant_ok;

  refr_rate_decode #(
    .BASE_HI(BASE_HI),
    .BASE_LO(BASE_LO),
    .CNT_W  (CNT_W)
  ) u_decode (
    .rate_code(rate_code),
    .freq_sel (freq_sel),
    .cfg_ok   (cfg_ok),
    .period   (period)
  );

  // Settings change detection; reset value matches "refresh off".
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= {rate_code, freq_sel};
  end
  assign reload = ({rate_code, freq_sel} != cfg_q);

  // Suspend handling.
  assign self_now = susp_req && susp_self;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) self_q <= 1'b0;
    else        self_q <= self_now;
  end

  // Timed refresh runs with the enable, or in suspend with timed refresh kept.
  assign run = cfg_ok && !self_now && (nref_en || susp_req);

  refr_interval_ctr #(
    .CNT_W(CNT_W)
  ) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .reload(reload),
    .period(period),
    .tick  (tick)
  );

  assign grant_ok = ref_gnt && ref_req;

  refr_owed_tracker #(
    .OWE_MAX(OWE_MAX),
    .OW     (OW)
  ) u_owed (
    .clk  (clk),
    .rst_n(rst_n),
    .add  (tick),
    .take (grant_ok),
    .owed (owed_cnt)
  );

  assign ref_req      = (owed_cnt != '0) && !self_q;
  assign self_ref_req = self_q;

endmodule

// File: rtl/refr_timer_chk.sv
module refr_timer_chk #(
  parameter int OWE_MAX = 8,
  parameter int OW      = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    rate_code,
  input logic          nref_en,
  input logic          susp_req,
  input logic          susp_self,
  input logic          ref_gnt,
  input logic          ref_req,
  input logic          self_ref_req,
  input logic [OW-1:0] owed_cnt,
  input logic          tick
);

  // R7: the owed count stays within its limit
  p_owed_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(owed_cnt) <= OWE_MAX);

  // R7: an expiry without a grant adds one below the limit
  p_tick_adds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(ref_req && ref_gnt) && int'(owed_cnt) < OWE_MAX)
    |=> int'(owed_cnt) == int'($past(owed_cnt)) + 1);

  // R6: an accepted grant without an expiry pays back one
  p_grant_takes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_gnt && !tick)
    |=> int'(owed_cnt) == int'($past(owed_cnt)) - 1);

  // R6: the request holds until granted unless self-refresh begins
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt && !(susp_req && susp_self)) |=> ref_req);

  // R2: codes without an interval never expire
  p_reserved_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code == 3'd0 || rate_code >= 3'd6) |-> !tick);

  // R5: no expiry with refresh disabled and no suspend
  p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!nref_en && !susp_req) |-> !tick);

  // R9: self-refresh and timed request never overlap
  p_self_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    self_ref_req |-> !ref_req);

  // R9: entering self-refresh is visible on the next edge
  p_self_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_req && susp_self) |=> self_ref_req);

endmodule

bind refr_timer refr_timer_chk #(
  .OWE_MAX(OWE_MAX),
  .OW     (OW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rate_code   (rate_code),
  .nref_en     (nref_en),
  .susp_req    (susp_req),
  .susp_self   (susp_self),
  .ref_gnt     (ref_gnt),
  .ref_req     (ref_req),
  .self_ref_req(self_ref_req),
  .owed_cnt    (owed_cnt),
  .tick        (tick)
);

// File: tb/refr_timer_tb.sv
`timescale 1ns/1ps
module refr_timer_tb;

  localparam int BHI  = 24;
  localparam int BLO  = 16;
  localparam int OMAX = 8;
  localparam int OW   = $clog2(OMAX + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    rate_code = '0;
  logic [1:0]    freq_sel = '0;
  logic          nref_en = 1'b0;
  logic          susp_req = 1'b0;
  logic          susp_self = 1'b0;
  logic          ref_gnt = 1'b0;
  logic          ref_req;
  logic          self_ref_req;
  logic [OW-1:0] owed_cnt;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    int    at;
    logic  req;
    logic  slf;
    int    owed;
    string tag;
  } exp_t;

  exp_t sb[$];
  exp_t cur;

  refr_timer #(.BASE_HI(BHI), .BASE_LO(BLO), .OWE_MAX(OMAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .rate_code(rate_code), .freq_sel(freq_sel),
    .nref_en(nref_en), .susp_req(susp_req), .susp_self(susp_self),
    .ref_gnt(ref_gnt), .ref_req(ref_req), .self_ref_req(self_ref_req),
    .owed_cnt(owed_cnt)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Driver side: expected output state at a given cycle count.
  task automatic expect_at(input int at, input logic req, input logic slf,
                           input int owed, input string tag);
    exp_t e;
    e.at = at; e.req = req; e.slf = slf; e.owed = owed; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Monitor side: compare away from the active edge.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      cur = sb.pop_front();
      checks++;
      if (cur.at != cyc) begin
        errors++;
        $display("FAIL %s: check missed, at %0d now %0d", cur.tag, cur.at, cyc);
      end else if (ref_req !== cur.req || self_ref_req !== cur.slf ||
                   int'(owed_cnt) != cur.owed) begin
        errors++;
        $display("FAIL %s @%0d: got req=%b self=%b owed=%0d, expected req=%b self=%b owed=%0d",
                 cur.tag, cyc, ref_req, self_ref_req, owed_cnt,
                 cur.req, cur.slf, cur.owed);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, got cycle %0d expected end", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t;
    repeat (3) @(negedge clk);
    // R1: reset state
    expect_at(cyc + 1, 1'b0, 1'b0, 0, "R1 in reset");
    wait_until(cyc + 2);
    rst_n = 1'b1;
    expect_at(cyc + 2, 1'b0, 1'b0, 0, "R1 after reset");
    wait_until(cyc + 3);

    // R2: off code and reserved codes, R4: reserved clock select
    t = cyc; nref_en = 1'b1; rate_code = 3'd0; freq_sel = 2'b00;
    expect_at(t + 60, 1'b0, 1'b0, 0, "R2 code 000");
    wait_until(t + 61);
    t = cyc; rate_code = 3'd6;
    expect_at(t + 60, 1'b0, 1'b0, 0, "R2 code 110");
    wait_until(t + 61);
    t = cyc; rate_code = 3'd7;
    expect_at(t + 60, 1'b0, 1'b0, 0, "R2 code 111");
    wait_until(t + 61);
    t = cyc; rate_code = 3'd1; freq_sel = 2'b01;
    expect_at(t + 60, 1'b0, 1'b0, 0, "R4 reserved select 01");
    wait_until(t + 61);

    // R3: code 001 at 100 MHz, interval BHI
    t = cyc; freq_sel = 2'b00;
    expect_at(t + 23, 1'b0, 1'b0, 0, "R3 before first expiry");
    expect_at(t + 24, 1'b1, 1'b0, 1, "R3 first expiry");
    wait_until(t + 30); ref_gnt = 1'b1;
    expect_at(t + 31, 1'b0, 1'b0, 0, "R6 grant pays back");
    wait_until(t + 31); ref_gnt = 1'b0;
    expect_at(t + 47, 1'b0, 1'b0, 0, "R3 before second expiry");
    expect_at(t + 48, 1'b1, 1'b0, 1, "R3 periodic expiry");
    // R7: pile up to the limit without grants
    expect_at(t + 216, 1'b1, 1'b0, 8, "R7 reaches limit");
    expect_at(t + 240, 1'b1, 1'b0, 8, "R7 saturates");
    wait_until(t + 263); ref_gnt = 1'b1;
    expect_at(t + 264, 1'b1, 1'b0, 8, "R7 expiry with grant");
    expect_at(t + 265, 1'b1, 1'b0, 7, "R6 grant at limit");
    wait_until(t + 265); ref_gnt = 1'b0;
    // R8: rate change restarts the interval and keeps owed refreshes
    wait_until(t + 270); rate_code = 3'd2;
    expect_at(t + 271, 1'b1, 1'b0, 7, "R8 owed kept on change");
    expect_at(t + 317, 1'b1, 1'b0, 7, "R8 no early expiry");
    expect_at(t + 318, 1'b1, 1'b0, 8, "R8 restarted interval");
    wait_until(t + 320); ref_gnt = 1'b1;
    expect_at(t + 328, 1'b0, 1'b0, 0, "R6 drain to zero");
    expect_at(t + 340, 1'b0, 1'b0, 0, "R6 grant ignored without request");
    wait_until(t + 340); ref_gnt = 1'b0;
    expect_at(t + 366, 1'b1, 1'b0, 1, "R3 code 010 interval");
    wait_until(t + 367);

    // R4: 66 MHz base, code 011
    t = cyc; rate_code = 3'd3; freq_sel = 2'b10; ref_gnt = 1'b1;
    expect_at(t + 1, 1'b0, 1'b0, 0, "R6 grant on change edge");
    wait_until(t + 1); ref_gnt = 1'b0;
    expect_at(t + 63, 1'b0, 1'b0, 0, "R4 before 66 MHz expiry");
    expect_at(t + 64, 1'b1, 1'b0, 1, "R4 66 MHz code 011");
    // R5: enable off stops the timer
    wait_until(t + 70); nref_en = 1'b0;
    expect_at(t + 200, 1'b1, 1'b0, 1, "R5 no expiry while disabled");
    wait_until(t + 200); nref_en = 1'b1;
    expect_at(t + 263, 1'b1, 1'b0, 1, "R5 full interval after enable");
    expect_at(t + 264, 1'b1, 1'b0, 2, "R5 expiry after enable");
    // R9: self-refresh suspend
    wait_until(t + 270); susp_req = 1'b1; susp_self = 1'b1;
    expect_at(t + 271, 1'b0, 1'b1, 2, "R9 enter self-refresh");
    wait_until(t + 275); ref_gnt = 1'b1;
    wait_until(t + 280); ref_gnt = 1'b0;
    expect_at(t + 290, 1'b0, 1'b1, 2, "R9 grant ignored, timer held");
    wait_until(t + 300); susp_req = 1'b0; susp_self = 1'b0;
    expect_at(t + 301, 1'b1, 1'b0, 2, "R9 leave self-refresh");
    expect_at(t + 363, 1'b1, 1'b0, 2, "R9 before resumed expiry");
    expect_at(t + 364, 1'b1, 1'b0, 3, "R9 resumed expiry");
    // R10: timed refresh in suspend without the enable
    wait_until(t + 370); nref_en = 1'b0; susp_req = 1'b1; susp_self = 1'b0;
    expect_at(t + 428, 1'b1, 1'b0, 4, "R10 timed refresh in suspend");
    wait_until(t + 430);
    susp_req = 1'b0; nref_en = 1'b1; rate_code = 3'd5; freq_sel = 2'b00;
    expect_at(t + 813, 1'b1, 1'b0, 4, "R3 before code 101 expiry");
    expect_at(t + 814, 1'b1, 1'b0, 5, "R3 code 101 interval");
    wait_until(t + 820); rate_code = 3'd6;
    expect_at(t + 1100, 1'b1, 1'b0, 5, "R2 reserved code mid-run");
    wait_until(t + 1110); rst_n = 1'b0;
    expect_at(t + 1111, 1'b0, 1'b0, 0, "R1 reset mid-run");
    wait_until(t + 1112); rst_n = 1'b1;
    wait_until(t + 1115);

    while (sb.size() > 0) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule